// File: doc/BRIEF.md
# Robust Nonlinear Signature Checker

This block guards a K-bit result word with R check bits that are not plain parity. The check bits are the multiplicative inverse, in GF(2^R), of the linear parity vector P·x. Because of that nonlinear step, whether an error is caught depends on the data word it lands on. No error pattern stays hidden for every word, the way some patterns do under a linear code. The block has two sides. An encoder side turns the word of the protected datapath into its signature. A verification side takes a possibly corrupted (data, signature) pair, rebuilds the signature with its own matrix multiply and its own inverse unit, and compares the two.

A received pair that is not a codeword raises `err_o` and blanks the released word. It also sets a sticky alarm that keeps every later released word at zero until reset, which disables the protected function. The verification path takes one registered cycle. Data bits travel unchanged, so the extended word is systematic: data first, signature after.

The parity matrix is a parameter with one K-bit row for each signature bit. The all-zero matrix, which is the default, selects the identity matrix. With K = R = 7 and the identity matrix the code is robust duplication, with codewords (x, x^-1).

Top module: `rsig_guard`

## Requirements
- R1: `pred_sig_o` equals the GF(2^R) inverse of P·`pred_data_i`. The field is reduced by x^7+x+1 (constant 0x83) by default, and P defaults to the identity, so that signature bit i is data bit i before inversion.
- R2: The inverse of the all-zero element is all-zero, so a zero parity vector gives a zero signature.
- R3: `out_valid_o` is high in exactly the cycle after a rising clock edge that samples `chk_valid_i` high, and low otherwise.
- R4: When `out_valid_o` is high, `err_o` is 1 exactly when the inverse of P·`chk_data_i` differs from `chk_sig_i`.
- R5: A word that passes the check while the alarm is clear comes out on `out_data_o` unchanged.
- R6: A word that fails the check is released as all-zero.
- R7: `alarm_o` rises in the same cycle as the first `err_o` and then stays high until reset. While it is high, every released word is zero, and `err_o` still reports each word's own check.
- R8: During reset and right after it, every output is zero. Reset clears the alarm.
- R9: With K = R = 7 and the identity matrix, every nonzero 14-bit error pattern, applied to three distinct data words, is flagged on at least one of them. The data error is the upper 7 bits and the signature error is the lower 7 bits.
- R10: While `out_valid_o` is low, `out_data_o` and `err_o` are zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| pred_data_i | input | K | Word from the protected datapath, to be encoded |
| pred_sig_o | output | R | Nonlinear signature of `pred_data_i` (combinational) |
| chk_valid_i | input | 1 | A received pair is present this cycle |
| chk_data_i | input | K | Received data part |
| chk_sig_i | input | R | Received signature part |
| out_valid_o | output | 1 | Verdict and released word are present |
| out_data_o | output | K | Released word, zero when flagged or alarmed |
| err_o | output | 1 | Received pair was not a codeword |
| alarm_o | output | 1 | Sticky alarm, set by any flagged pair |

## Verification
The assertions assume that `chk_valid_i` is held low while reset is active and takes known values once reset is released. The bench drives every input from falling clock edges and keeps `chk_valid_i` low in every reset window. The properties about released data hold for any stimulus, so the bench makes no promise about codeword content. It drives clean pairs, single corruptions and the full space of 16383 error patterns, each pattern applied to three fixed, distinct words.

// File: rtl/rsig_pkg.sv
package rsig_pkg;
  localparam int unsigned DEF_K = 7;
  localparam int unsigned DEF_R = 7;
  // x^7 + x + 1
  localparam logic [7:0]  DEF_POLY = 8'h83;
endpackage

// File: rtl/rsig_lin_map.sv
// Parity vector P·x over GF(2); row i of P sits at ROWS[i*K +: K].
module rsig_lin_map #(
  parameter int unsigned K = 7,
  parameter int unsigned R = 7,
  parameter logic [R*K-1:0] ROWS = '0
) (
  input  logic [K-1:0] word_i,
  output logic [R-1:0] par_o
);
  for (genvar i = 0; i < R; i++) begin : g_row
    assign par_o[i] = ^(word_i & ROWS[i*K +: K]);
  end
endmodule

// File: rtl/rsig_gf_inv.sv
// Combinational GF(2^R) inverse by square-and-multiply: a^(2^R - 2).
module rsig_gf_inv #(
  parameter int unsigned R = 7,
  parameter logic [R:0] POLY = 8'h83
) (
  input  logic [R-1:0] a_i,
  output logic [R-1:0] inv_o
);
  localparam logic [R-1:0] RED = POLY[R-1:0];

  function automatic logic [R-1:0] gf_mul(input logic [R-1:0] a, input logic [R-1:0] b);
    logic [R-1:0] acc;
    logic [R-1:0] sh;
    acc = '0;
    sh  = a;
    for (int i = 0; i < R; i++) begin
      if (b[i]) acc = acc ^ sh;
      sh = {sh[R-2:0], 1'b0} ^ (sh[R-1] ? RED : '0);
    end
    return acc;
  endfunction

  // exponent 2^R-2 = 2 + 4 + ... + 2^(R-1); zero maps to zero
  function automatic logic [R-1:0] gf_inv(input logic [R-1:0] a);
    logic [R-1:0] base;
    logic [R-1:0] res;
    base = a;
    res  = {{(R-1){1'b0}}, 1'b1};
    for (int i = 1; i < R; i++) begin
      base = gf_mul(base, base);
      res  = gf_mul(res, base);
    end
    return res;
  endfunction

  assign inv_o = gf_inv(a_i);
endmodule

// File: rtl/rsig_verdict.sv
// Registered verdict, output blanking and sticky alarm.
module rsig_verdict #(
  parameter int unsigned K = 7
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         valid_i,
  input  logic [K-1:0] data_i,
  input  logic         mismatch_i,
  output logic         out_valid_o,
  output logic [K-1:0] out_data_o,
  output logic         err_o,
  output logic         alarm_o
);
  logic hit;
  logic release_ok;

  assign hit        = valid_i & mismatch_i;
  assign release_ok = valid_i & ~mismatch_i & ~alarm_o;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      out_valid_o <= 1'b0;
      out_data_o  <= '0;
      err_o       <= 1'b0;
      alarm_o     <= 1'b0;
    end else begin
      out_valid_o <= valid_i;
      err_o       <= hit;
      alarm_o     <= alarm_o | hit;
      out_data_o  <= release_ok ? data_i : '0;
    end
  end
endmodule

// File: rtl/rsig_guard.sv
module rsig_guard #(
  parameter int unsigned K = rsig_pkg::DEF_K,
  parameter int unsigned R = rsig_pkg::DEF_R,
  parameter logic [R:0]  POLY = rsig_pkg::DEF_POLY,
  // all-zero selects the identity matrix
  parameter logic [R*K-1:0] P_ROWS = '0
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [K-1:0] pred_data_i,
  output logic [R-1:0] pred_sig_o,
  input  logic         chk_valid_i,
  input  logic [K-1:0] chk_data_i,
  input  logic [R-1:0] chk_sig_i,
  output logic         out_valid_o,
  output logic [K-1:0] out_data_o,
  output logic         err_o,
  output logic         alarm_o
);
  function automatic logic [R*K-1:0] ident_rows();
    logic [R*K-1:0] m;
    m = '0;
    for (int i = 0; i < R; i++) begin
      if (i < K) m[i*K + i] = 1'b1;
    end
    return m;
  endfunction

  localparam logic [R*K-1:0] P_EFF = (P_ROWS == '0) ? ident_rows() : P_ROWS;

  // named internal events
  logic [R-1:0] pred_par;
  logic [R-1:0] chk_par;
  logic [R-1:0] chk_recalc;
  logic         chk_mismatch;

  rsig_lin_map #(.K(K), .R(R), .ROWS(P_EFF)) u_pred_map (
    .word_i (pred_data_i),
    .par_o  (pred_par)
  );

  rsig_gf_inv #(.R(R), .POLY(POLY)) u_pred_inv (
    .a_i   (pred_par),
    .inv_o (pred_sig_o)
  );

  rsig_lin_map #(.K(K), .R(R), .ROWS(P_EFF)) u_chk_map (
    .word_i (chk_data_i),
    .par_o  (chk_par)
  );

  rsig_gf_inv #(.R(R), .POLY(POLY)) u_chk_inv (
    .a_i   (chk_par),
    .inv_o (chk_recalc)
  );

  assign chk_mismatch = (chk_recalc != chk_sig_i);

  rsig_verdict #(.K(K)) u_verdict (
    .clk         (clk),
    .rst_n       (rst_n),
    .valid_i     (chk_valid_i),
    .data_i      (chk_data_i),
    .mismatch_i  (chk_mismatch),
    .out_valid_o (out_valid_o),
    .out_data_o  (out_data_o),
    .err_o       (err_o),
    .alarm_o     (alarm_o)
  );
endmodule

// File: rtl/rsig_guard_sva.sv
module rsig_guard_sva #(
  parameter int unsigned K = 7,
  parameter int unsigned R = 7
) (
  input logic         clk,
  input logic         rst_n,
  input logic [K-1:0] pred_data_i,
  input logic [R-1:0] pred_sig_o,
  input logic         chk_valid_i,
  input logic [K-1:0] chk_data_i,
  input logic         chk_mismatch,
  input logic         out_valid_o,
  input logic [K-1:0] out_data_o,
  input logic         err_o,
  input logic         alarm_o
);
  a_r2_zero_to_zero: assert property (@(posedge clk) disable iff (!rst_n)
    (pred_data_i == '0) |-> (pred_sig_o == '0));

  a_r3_valid_follows: assert property (@(posedge clk) disable iff (!rst_n)
    chk_valid_i |=> out_valid_o);

  a_r3_no_spurious: assert property (@(posedge clk) disable iff (!rst_n)
    !chk_valid_i |=> !out_valid_o);

  a_r4_flag_tracks: assert property (@(posedge clk) disable iff (!rst_n)
    (chk_valid_i && chk_mismatch) |=> err_o);

  a_r5_clean_release: assert property (@(posedge clk) disable iff (!rst_n)
    (out_valid_o && !err_o && !alarm_o) |-> (out_data_o == $past(chk_data_i)));

  a_r6_blank_on_err: assert property (@(posedge clk) disable iff (!rst_n)
    err_o |-> (out_data_o == '0));

  a_r7_alarm_sticky: assert property (@(posedge clk) disable iff (!rst_n)
    alarm_o |=> alarm_o);

  a_r7_err_sets_alarm: assert property (@(posedge clk) disable iff (!rst_n)
    err_o |-> alarm_o);

  a_r7_alarm_blanks: assert property (@(posedge clk) disable iff (!rst_n)
    alarm_o |-> (out_data_o == '0));

  a_r10_idle_quiet: assert property (@(posedge clk) disable iff (!rst_n)
    !out_valid_o |-> (out_data_o == '0 && !err_o));
endmodule

bind rsig_guard rsig_guard_sva #(.K(K), .R(R)) u_sva (
  .clk          (clk),
  .rst_n        (rst_n),
  .pred_data_i  (pred_data_i),
  .pred_sig_o   (pred_sig_o),
  .chk_valid_i  (chk_valid_i),
  .chk_data_i   (chk_data_i),
  .chk_mismatch (chk_mismatch),
  .out_valid_o  (out_valid_o),
  .out_data_o   (out_data_o),
  .err_o        (err_o),
  .alarm_o      (alarm_o)
);

// File: tb/rsig_guard_tb_top.sv
`timescale 1ns/1ps
module rsig_guard_tb_top;
  localparam int K = 7;
  localparam int R = 7;

  logic         clk = 1'b0;
  logic         rst_n = 1'b0;
  logic [K-1:0] pred_data_i = '0;
  logic [R-1:0] pred_sig_o;
  logic         chk_valid_i = 1'b0;
  logic [K-1:0] chk_data_i = '0;
  logic [R-1:0] chk_sig_i = '0;
  logic         out_valid_o;
  logic [K-1:0] out_data_o;
  logic         err_o;
  logic         alarm_o;

  always #10 clk = ~clk;

  rsig_guard dut_i (
    .clk, .rst_n, .pred_data_i, .pred_sig_o, .chk_valid_i, .chk_data_i,
    .chk_sig_i, .out_valid_o, .out_data_o, .err_o, .alarm_o
  );

  typedef struct {
    logic         err;
    logic [K-1:0] data;
    logic         alarm;
    int           grp;
    logic         last;
  } exp_t;

  exp_t   sb_q[$];
  int     n_checks = 0;
  int     n_fail = 0;
  logic   model_alarm = 1'b0;
  logic   grp_seen = 1'b0;
  logic   ended = 1'b0;
  logic [6:0] inv_t [128];

  // polynomial product then long-division reduction by 0x83
  function automatic logic [6:0] tb_mul(input logic [6:0] a, input logic [6:0] b);
    logic [12:0] p;
    p = '0;
    for (int i = 0; i < 7; i++) if (b[i]) p = p ^ (13'(a) << i);
    for (int j = 12; j >= 7; j--) if (p[j]) p = p ^ (13'h83 << (j - 7));
    return p[6:0];
  endfunction

  task automatic check(input string req, input logic ok, input string what,
                       input int act, input int expv);
    n_checks++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s %s: actual %0h expected %0h", req, what, act, expv);
    end
  endtask

  task automatic finish_run();
    if (!ended) begin
      ended = 1'b1;
      $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
      $finish;
    end
  endtask

  // driver: present a pair with an optional error, push expectation
  task automatic send(input logic [6:0] x, input logic [6:0] ex, input logic [6:0] ev,
                      input int grp, input logic last);
    exp_t e;
    logic [6:0] xd;
    logic [6:0] vd;
    logic       mis;
    @(negedge clk);
    xd  = x ^ ex;
    vd  = inv_t[x] ^ ev;
    mis = (inv_t[xd] != vd);
    e.err   = mis;
    e.data  = (mis || model_alarm) ? 7'h00 : xd;
    model_alarm = model_alarm | mis;
    e.alarm = model_alarm;
    e.grp   = grp;
    e.last  = last;
    chk_valid_i = 1'b1;
    chk_data_i  = xd;
    chk_sig_i   = vd;
    sb_q.push_back(e);
  endtask

  task automatic idle(input int n);
    repeat (n) begin
      @(negedge clk);
      chk_valid_i = 1'b0;
    end
  endtask

  // monitor
  always @(negedge clk) begin
    if (rst_n && !ended) begin
      if (out_valid_o) begin
        if (sb_q.size() == 0) begin
          check("R3", 1'b0, "unexpected out_valid", 1, 0);
        end else begin
          exp_t e;
          e = sb_q.pop_front();
          check("R4", err_o == e.err, "err", err_o, e.err);
          check(e.err ? "R6" : (e.alarm ? "R7" : "R5"), out_data_o == e.data,
                "data", out_data_o, e.data);
          check("R7", alarm_o == e.alarm, "alarm", alarm_o, e.alarm);
          if (e.grp >= 0) begin
            grp_seen = grp_seen | err_o;
            if (e.last) begin
              check("R9", grp_seen, "detections over three words", grp_seen, 1);
              grp_seen = 1'b0;
            end
          end
        end
      end else begin
        check("R10", out_data_o == '0 && !err_o, "idle outputs",
              {out_data_o, err_o}, 0);
      end
    end
  end

  initial begin
    #(20ns * 190000);
    n_fail++;
    $display("FAIL watchdog: actual timeout expected completion");
    finish_run();
  end

  initial begin
    inv_t[0] = 7'h00;
    for (int a = 1; a < 128; a++) begin
      inv_t[a] = 7'h00;
      for (int b = 1; b < 128; b++) if (tb_mul(7'(a), 7'(b)) == 7'h01) inv_t[a] = 7'(b);
    end

    // R8: reset state
    repeat (3) @(negedge clk);
    check("R8", !out_valid_o && out_data_o == '0 && !err_o && !alarm_o,
          "outputs in reset", {out_valid_o, out_data_o, err_o, alarm_o}, 0);
    rst_n = 1'b1;
    @(negedge clk);
    check("R8", !out_valid_o && !alarm_o, "outputs after reset",
          {out_valid_o, alarm_o}, 0);

    // R1, R2: encoder side over every word
    for (int x = 0; x < 128; x++) begin
      pred_data_i = 7'(x);
      #1;
      if (x == 0) check("R2", pred_sig_o == 7'h00, "zero signature", pred_sig_o, 0);
      else check("R1", pred_sig_o == inv_t[x], "signature", pred_sig_o, inv_t[x]);
    end

    // R5: every clean codeword released unchanged
    for (int x = 0; x < 128; x++) send(7'(x), 7'h00, 7'h00, -1, 1'b0);
    // R3: gap, then back-to-back words
    idle(3);
    send(7'h2B, 7'h00, 7'h00, -1, 1'b0);
    send(7'h54, 7'h00, 7'h00, -1, 1'b0);
    // R6, R7: one corrupted word, then clean words stay blanked
    send(7'h11, 7'h00, 7'h01, -1, 1'b0);
    send(7'h22, 7'h00, 7'h00, -1, 1'b0);
    send(7'h33, 7'h00, 7'h00, -1, 1'b0);
    idle(4);
    check("R7", alarm_o == 1'b1, "alarm held while idle", alarm_o, 1);

    // R8: reset clears the alarm, clean words pass again
    rst_n = 1'b0;
    model_alarm = 1'b0;
    idle(2);
    check("R8", !alarm_o && !out_valid_o, "alarm cleared by reset", alarm_o, 0);
    rst_n = 1'b1;
    send(7'h66, 7'h00, 7'h00, -1, 1'b0);
    send(7'h3C, 7'h40, 7'h00, -1, 1'b0);  // data-bit error
    send(7'h3C, 7'h00, 7'h00, -1, 1'b0);
    idle(2);

    // R9: every nonzero error pattern over three distinct words
    for (int e = 1; e < (1 << 14); e++) begin
      send(7'h05, 7'(e >> 7), 7'(e), e, 1'b0);
      send(7'h3A, 7'(e >> 7), 7'(e), e, 1'b0);
      send(7'h61, 7'(e >> 7), 7'(e), e, 1'b1);
    end
    idle(3);
    check("R3", sb_q.size() == 0, "outstanding results", sb_q.size(), 0);
    finish_run();
  end
endmodule